// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns parallel bytes into asynchronous serial frames on a single output line. The frame shape comes from a line-control byte: it sets the word length (5 to 8 bits), whether a parity bit is sent and of which sense, and one or two stop bits. A further bit of the same byte holds the line in the break condition. The bit rate comes from a 16-bit divisor applied to a reference tick. Each pulse of that tick stands for one bit period at the 115200 base rate, so a bit lasts `divisor` reference ticks.

Bytes enter through a valid/ready handshake. When a byte is accepted, the block latches the control byte and the divisor. The frame then runs to completion with those values, whatever happens to the inputs afterwards. A zero divisor keeps the handshake closed, so no frame can start. The idle flag reports an empty transmitter to a surrounding register block, and the busy flag is its complement.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, the serial line is high, idle is 1, busy is 0, and no frame is in progress.
- R2: A frame starts on the cycle after a byte is accepted (valid and ready both high at a clock edge). It sends, in order: one low start bit, the data bits with the least significant bit first, the parity bit if enabled, and then high stop bits. Between frames the line is high.
- R3: The number of data bits is control bits [1:0] plus 5 (00 gives 5 and 11 gives 8). Input bits above the configured word length are never sent.
- R4: Control bit 2 set gives two stop bits. Control bit 2 clear gives one stop bit.
- R5: Control bit 3 set adds a parity bit. When parity is on, control bit 4 set selects even parity, so the count of ones over data and parity is even. Bit 4 clear selects odd parity. Parity covers only the configured data bits.
- R6: Each bit lasts exactly `divisor` reference ticks. While the reference tick is absent the frame does not advance: the line holds its bit and busy stays high.
- R7: While the divisor is zero, ready is low, a presented byte is not taken, and the line stays idle-high.
- R8: While control bit 6 is set, the line is driven low. A frame in progress keeps its bit timing and finishes on schedule.
- R9: The control byte and divisor are captured when a byte is accepted. Changing them during a frame affects only later frames. The break bit is the exception and acts at once.
- R10: Ready is high only when the transmitter is idle and the divisor is nonzero. Idle is high exactly when no frame is in progress, and busy is its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | Reference tick, one pulse per base-rate bit period |
| line_ctrl_i | input | 8 | Line control: [1:0] length, [2] stop, [3] parity on, [4] even, [6] break |
| divisor_i | input | 16 | Bit-rate divisor in reference ticks per bit |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte on data_i is offered |
| ready_o | output | 1 | Transmitter can accept a byte |
| txd_o | output | 1 | Serial output line |
| busy_o | output | 1 | A frame is in progress |
| idle_o | output | 1 | Transmitter empty |

## Verification
The checker watches several properties on every cycle:
- ready never rises with a zero divisor or while a frame runs;
- break always pulls the line low;
- an idle line without break is high;
- an accepted byte produces a low start bit on the next cycle;
- a frame cannot end in a cycle without a reference tick.

The bench scenarios show what the checker cannot: the exact bit sequence and its length for each word length, parity sense and stop count, including upper input bits that are never sent. They also show the bit duration for several divisors. Finally, they show that format and divisor changes made during a frame are ignored until the next one.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int MAX_BITS = 8;
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] last_idx;
        logic             par_en;
        logic             par_even;
        logic             two_stop;
    } frame_fmt_t;

    function automatic frame_fmt_t decode_fmt(input logic [4:0] ctrl);
        frame_fmt_t f;
        f.last_idx = IDX_W'(ctrl[1:0]) + IDX_W'(4);
        f.two_stop = ctrl[2];
        f.par_en   = ctrl[3];
        f.par_even = ctrl[4];
        return f;
    endfunction

    function automatic logic [MAX_BITS-1:0] word_mask(input logic [IDX_W-1:0] last_idx);
        return {MAX_BITS{1'b1}} >> (IDX_W'(MAX_BITS - 1) - last_idx);
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             run_i,
    input  logic             ref_tick_i,
    output logic             bit_tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } baud_regs_t;

    baud_regs_t r_q, r_d;
    logic       at_end;

    assign at_end     = (r_q.cnt == (r_q.div - {{(DIV_W-1){1'b0}}, 1'b1}));
    assign bit_tick_o = run_i && ref_tick_i && at_end;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.div = div_i;
            r_d.cnt = '0;
        end else if (run_i && ref_tick_i) begin
            if (at_end) begin
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + {{(DIV_W-1){1'b0}}, 1'b1};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/uart_frame_shift.sv
module uart_frame_shift
    import uart_tx_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [4:0]          fmt_ctrl_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic                bit_tick_i,
    output logic                line_o,
    output logic                active_o
);

    typedef struct packed {
        tx_state_e          state;
        frame_fmt_t         fmt;
        logic [MAX_BITS-1:0] shreg;
        logic [IDX_W-1:0]   bit_idx;
        logic               par_bit;
        logic               stop_left;
    } shift_regs_t;

    shift_regs_t r_q, r_d;
    frame_fmt_t  new_fmt;
    logic        raw_par;

    assign new_fmt  = decode_fmt(fmt_ctrl_i);
    assign raw_par  = ^(data_i & word_mask(new_fmt.last_idx));
    assign active_o = (r_q.state != ST_IDLE);

    always_comb begin
        unique case (r_q.state)
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = r_q.shreg[0];
            ST_PAR:   line_o = r_q.par_bit;
            default:  line_o = 1'b1;
        endcase
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state   = ST_START;
                    r_d.fmt     = new_fmt;
                    r_d.shreg   = data_i;
                    r_d.bit_idx = '0;
                    r_d.par_bit = new_fmt.par_even ? raw_par : ~raw_par;
                end
            end
            ST_START: begin
                if (bit_tick_i) begin
                    r_d.state   = ST_DATA;
                    r_d.bit_idx = '0;
                end
            end
            ST_DATA: begin
                if (bit_tick_i) begin
                    if (r_q.bit_idx == r_q.fmt.last_idx) begin
                        if (r_q.fmt.par_en) begin
                            r_d.state = ST_PAR;
                        end else begin
                            r_d.state     = ST_STOP;
                            r_d.stop_left = r_q.fmt.two_stop;
                        end
                    end else begin
                        r_d.bit_idx = r_q.bit_idx + IDX_W'(1);
                        r_d.shreg   = r_q.shreg >> 1;
                    end
                end
            end
            ST_PAR: begin
                if (bit_tick_i) begin
                    r_d.state     = ST_STOP;
                    r_d.stop_left = r_q.fmt.two_stop;
                end
            end
            ST_STOP: begin
                if (bit_tick_i) begin
                    if (r_q.stop_left) begin
                        r_d.stop_left = 1'b0;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_tick_i,
    input  logic [7:0]       line_ctrl_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic [7:0]       data_i,
    input  logic             valid_i,
    output logic             ready_o,
    output logic             txd_o,
    output logic             busy_o,
    output logic             idle_o
);

    logic active;
    logic start;
    logic bit_tick;
    logic line;
    logic ctrl_unused;

    assign ctrl_unused = line_ctrl_i[7] ^ line_ctrl_i[5];

    assign ready_o = !active && (divisor_i != '0);
    assign start   = valid_i && ready_o;
    assign busy_o  = active;
    assign idle_o  = !active;
    assign txd_o   = line && !line_ctrl_i[6];

    uart_baud_gen #(
        .DIV_W(DIV_W)
    ) baud_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (start),
        .div_i      (divisor_i),
        .run_i      (active),
        .ref_tick_i (ref_tick_i),
        .bit_tick_o (bit_tick)
    );

    uart_frame_shift shift_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start),
        .fmt_ctrl_i (line_ctrl_i[4:0]),
        .data_i     (data_i),
        .bit_tick_i (bit_tick),
        .line_o     (line),
        .active_o   (active)
    );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ref_tick_i,
    input logic [7:0]       line_ctrl_i,
    input logic [DIV_W-1:0] divisor_i,
    input logic             valid_i,
    input logic             ready_o,
    input logic             txd_o,
    input logic             busy_o,
    input logic             idle_o
);

    // R7
    zero_div_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (divisor_i == '0) |-> !ready_o);

    // R10
    ready_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (idle_o && !busy_o));

    // R8
    break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_ctrl_i[6] |-> !txd_o);

    // R2
    idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle_o && !line_ctrl_i[6]) |-> txd_o);

    // R2
    start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o) |=> (!txd_o && busy_o));

    // R6
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !ref_tick_i) |=> busy_o);

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DIV_W(DIV_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_tick_i  (ref_tick_i),
    .line_ctrl_i (line_ctrl_i),
    .divisor_i   (divisor_i),
    .valid_i     (valid_i),
    .ready_o     (ready_o),
    .txd_o       (txd_o),
    .busy_o      (busy_o),
    .idle_o      (idle_o)
);

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic [7:0]  ctrl = 8'h03;
    logic [15:0] div = 16'd4;
    logic [7:0]  data = 8'h00;
    logic        valid = 1'b0;
    logic        ready, txd, busy, idle;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_frame_tx dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ref_tick_i  (ref_tick),
        .line_ctrl_i (ctrl),
        .divisor_i   (div),
        .data_i      (data),
        .valid_i     (valid),
        .ready_o     (ready),
        .txd_o       (txd),
        .busy_o      (busy),
        .idle_o      (idle)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(txd == 1'b1, "R1 line", int'(txd), 1);
        check(idle == 1'b1 && busy == 1'b0, "R1 idle/busy", int'({idle, busy}), 2);
        check(ready == 1'b1, "R10 ready when idle", int'(ready), 1);
    endtask

    // Sends one byte and checks every bit in its middle; the format is taken from
    // c/d, while c_after/d_after are applied right after acceptance.
    task automatic send_frame(input logic [7:0] c, input logic [7:0] b, input logic [15:0] d,
                              input logic [7:0] c_after, input logic [15:0] d_after,
                              input string tag);
        logic exp_bits [0:11];
        int   n, nb, h;
        logic p;
        n = int'(c[1:0]) + 5;
        nb = 0;
        exp_bits[nb++] = 1'b0;
        for (int i = 0; i < n; i++) exp_bits[nb++] = b[i];
        if (c[3]) begin
            p = 1'b0;
            for (int i = 0; i < n; i++) p ^= b[i];
            exp_bits[nb++] = c[4] ? p : ~p;
        end
        exp_bits[nb++] = 1'b1;
        if (c[2]) exp_bits[nb++] = 1'b1;
        if (c[6]) for (int i = 0; i < nb; i++) exp_bits[i] = 1'b0;

        @(negedge clk);
        ctrl = c; div = d; data = b; valid = 1'b1;
        @(posedge clk);
        #1 valid = 1'b0; ctrl = c_after; div = d_after;
        h = int'(d) / 2;
        for (int j = 0; j < nb; j++) begin
            repeat (h) @(posedge clk);
            @(negedge clk);
            check(txd == exp_bits[j], $sformatf("%s bit%0d", tag, j), int'(txd), int'(exp_bits[j]));
            check(busy == 1'b1, $sformatf("%s busy bit%0d", tag, j), int'(busy), 1);
            repeat (int'(d) - h) @(posedge clk);
        end
        @(negedge clk);
        check(idle == 1'b1, {tag, " R10 idle at frame end"}, int'(idle), 1);
        check(ready == (d_after != 0), {tag, " R10 ready at frame end"}, int'(ready), int'(d_after != 0));
    endtask

    task automatic t_zero_div();
        @(negedge clk);
        div = 16'd0; data = 8'h55; valid = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(ready == 1'b0 && txd == 1'b1 && idle == 1'b1, "R7 zero divisor stalls",
                  int'({ready, txd, idle}), 3);
        end
        valid = 1'b0; div = 16'd4;
        @(negedge clk);
        check(ready == 1'b1, "R10 ready after divisor set", int'(ready), 1);
    endtask

    task automatic t_ref_stall();
        @(negedge clk);
        ctrl = 8'h03; div = 16'd2; data = 8'h00; valid = 1'b1;
        @(posedge clk);
        #1 valid = 1'b0; ref_tick = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(txd == 1'b0 && busy == 1'b1, "R6 no reference tick holds frame",
                  int'({txd, busy}), 1);
        end
        ref_tick = 1'b1;
        repeat (19) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b1, "R6 frame still in last stop bit", int'(busy), 1);
        @(posedge clk);
        @(negedge clk);
        check(idle == 1'b1, "R6 frame done after 10 bits x 2", int'(idle), 1);
    endtask

    task automatic t_break_idle();
        @(negedge clk);
        ctrl = 8'h43;
        @(negedge clk);
        check(txd == 1'b0, "R8 break while idle", int'(txd), 0);
        ctrl = 8'h03;
        @(negedge clk);
        check(txd == 1'b1, "R8 release break", int'(txd), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        send_frame(8'h03, 8'hA5, 16'd4, 8'h03, 16'd4, "R2 8N1");
        send_frame(8'h00, 8'hE3, 16'd4, 8'h00, 16'd4, "R3 5N1 upper ignored");
        send_frame(8'h1E, 8'h35, 16'd3, 8'h1E, 16'd3, "R4 R5 7E2");
        send_frame(8'h09, 8'hC1, 16'd5, 8'h09, 16'd5, "R5 6O1 upper ignored");
        send_frame(8'h1B, 8'h7F, 16'd1, 8'h1B, 16'd1, "R5 R6 8E1 div1");
        send_frame(8'h01, 8'h2A, 16'd7, 8'h01, 16'd7, "R6 6N1 div7");
        send_frame(8'h03, 8'h96, 16'd3, 8'h1C, 16'd9, "R9 change mid-frame");
        send_frame(8'h1C, 8'h13, 16'd9, 8'h1C, 16'd9, "R9 next frame uses new");
        send_frame(8'h4B, 8'h5A, 16'd2, 8'h4B, 16'd2, "R8 break during frame");
        t_break_idle();
        t_zero_div();
        t_ref_stall();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule